// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an eight-bit general-purpose I/O port that sits on a small register bus. Software uses three registers. The direction register sets each pin as input or output. The output latch holds the value to drive. The pin register returns the levels seen on the pads after synchronization. Writing either the pin register or the latch register updates the latch. Reading the latch returns the stored output value and never the pad level, so read-modify-write sequences do not pick up stray pin levels.

Several side inputs shape the port:

- An analog-select mask blanks the digital readback of chosen pins. Those pins keep their output driver under latch and direction control.
- A pin-available mask, set by the clock configuration, removes pins from port use entirely. An unavailable pin never drives, reads zero in all three registers, ignores writes and keeps its stored bits cleared.
- Two peripheral overrides each replace the latch value on one fixed bit while enabled. The direction bit still decides whether that bit is driven.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads all ones (every available pin is an input), the latch reads 0, pin_oe is 0 and bus_rdata is 0.
- R2: A direction bit of 0 on an available pin sets pin_oe for that bit and puts the latch bit on pin_out. A direction bit of 1 clears pin_oe for that bit.
- R3: A write to offset 0 (pin register) or to offset 1 (latch register) loads bus_wdata into the latch. A write to offset 2 loads the direction register.
- R4: A read of offset 1 returns the latch contents even when the pad levels differ from it.
- R5: A read of offset 0 returns the pad levels after a two-flop synchronizer. A pad change made before rising edge k is visible on bus_rdata after edge k+2, provided offset 0 is selected at that edge.
- R6: Bits set in ana_sel read 0 at offset 0. The latch and direction bits of those pins, and their pin_oe, are unaffected.
- R7: Bits clear in pin_avail read 0 at offsets 0, 1 and 2 and never set pin_oe. Writes to those bits are ignored. Their stored latch and direction bits are cleared, so they stay 0 after the pin becomes available again.
- R8: While ovr_a_en is 1, pin_out bit 4 equals ovr_a_val. While ovr_b_en is 1, pin_out bit 5 equals ovr_b_val. Overrides never change the latch contents or pin_oe.
- R9: Offset 3 is unmapped. It reads 0 and a write to it changes no register.
- R10: bus_rdata is registered. It shows the register selected by bus_addr at the previous rising edge, so a new address has no effect on bus_rdata before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset: 0 pin, 1 latch, 2 direction, 3 unmapped |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_out | output | 8 | Value presented to each pad driver |
| pin_oe | output | 8 | Pad driver enable, 1 = drive |
| pin_in | input | 8 | Pad input levels, asynchronous |
| ana_sel | input | 8 | Per-bit analog select, 1 = digital readback blanked |
| pin_avail | input | 8 | Per-bit availability for port use, 0 = pin claimed elsewhere |
| ovr_a_en | input | 1 | Enables the override on bit 4 |
| ovr_a_val | input | 1 | Override value for bit 4 |
| ovr_b_en | input | 1 | Enables the override on bit 5 |
| ovr_b_val | input | 1 | Override value for bit 5 |

## Verification
A corrupted latch or direction bit shows at once on pin_out or pin_oe. It also shows one edge after a read of offset 1 or 2. A synchronizer stage that is missing or stuck shows as the wrong latency, or a wrong value, on a pin-register read, two edges after a pad change. Masking faults are easiest to see with pads held at all ones: a missing analog or availability mask turns up as stray ones in read data. A mask that fails to clear storage turns up after the pin becomes available again.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // True when a write at this offset lands in the output latch.
  function automatic logic hits_latch(input reg_sel_e sel);
    return (sel == SEL_PIN) || (sel == SEL_LAT);
  endfunction

  // True when a write at this offset lands in the direction register.
  function automatic logic hits_dir(input reg_sel_e sel);
    return sel == SEL_DIR;
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] avail,
  output logic [WIDTH-1:0] lat_o,
  output logic [WIDTH-1:0] dir_o,
  output logic             lat_wr,
  output logic             dir_wr
);
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;

  // Unavailable bits are forced to zero on every edge, written or not.
  function automatic logic [WIDTH-1:0] keep_avail(input logic [WIDTH-1:0] v,
                                                  input logic [WIDTH-1:0] m);
    return v & m;
  endfunction

  assign lat_wr = wr && hits_latch(sel);
  assign dir_wr = wr && hits_dir(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      lat_q <= keep_avail(lat_wr ? wdata : lat_q, avail);
      dir_q <= keep_avail(dir_wr ? wdata : dir_q, avail);
    end
  end

  // The reset value of dir_q is all ones, so the view is masked as well.
  assign lat_o = keep_avail(lat_q, avail);
  assign dir_o = keep_avail(dir_q, avail);

  // R3
  lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr |=> lat_q == ($past(wdata) & $past(avail)));

  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> dir_q == ($past(wdata) & $past(avail)));

  // R9
  lat_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_wr |=> (lat_q & ~$past(lat_q)) == '0);

  // R7
  unavail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q | dir_q) & ~$past(avail)) == '0);
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_lat2
      // R5
      sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ##2 (sync_o == $past(pin_in, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned OVR_A_BIT = 4,
  parameter int unsigned OVR_B_BIT = 5
) (
  input  logic [WIDTH-1:0] lat,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] avail,
  input  logic             ovr_a_en,
  input  logic             ovr_a_val,
  input  logic             ovr_b_en,
  input  logic             ovr_b_val,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  // Output value of one bit: an enabled override wins over the latch.
  function automatic logic pick(input logic en, input logic val, input logic l);
    return en ? val : l;
  endfunction

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign pin_oe[b] = ~dir[b] & avail[b];
      if (b == OVR_A_BIT) begin : g_ova
        assign pin_out[b] = pick(ovr_a_en, ovr_a_val, lat[b]);
      end else if (b == OVR_B_BIT) begin : g_ovb
        assign pin_out[b] = pick(ovr_b_en, ovr_b_val, lat[b]);
      end else begin : g_plain
        assign pin_out[b] = lat[b];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OVR_A_BIT   = 4,
  parameter int unsigned OVR_B_BIT   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] ana_sel,
  input  logic [WIDTH-1:0] pin_avail,
  input  logic             ovr_a_en,
  input  logic             ovr_a_val,
  input  logic             ovr_b_en,
  input  logic             ovr_b_val
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] lat_v, dir_v, sync_v, pin_view;
  logic             lat_wr, dir_wr;
  logic [WIDTH-1:0] rdata_q;

  assign sel = reg_sel_e'(bus_addr);

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .avail(pin_avail), .lat_o(lat_v), .dir_o(dir_v),
    .lat_wr(lat_wr), .dir_wr(dir_wr)
  );

  gpio_insync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_o(sync_v)
  );

  gpio_drive #(.WIDTH(WIDTH), .OVR_A_BIT(OVR_A_BIT), .OVR_B_BIT(OVR_B_BIT)) u_drive (
    .lat(lat_v), .dir(dir_v), .avail(pin_avail),
    .ovr_a_en(ovr_a_en), .ovr_a_val(ovr_a_val),
    .ovr_b_en(ovr_b_en), .ovr_b_val(ovr_b_val),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Digital readback of the pads: analog-selected or unavailable bits read 0.
  function automatic logic [WIDTH-1:0] gate_pins(input logic [WIDTH-1:0] s,
                                                 input logic [WIDTH-1:0] ana,
                                                 input logic [WIDTH-1:0] av);
    return s & ~ana & av;
  endfunction

  function automatic logic [WIDTH-1:0] read_mux(input reg_sel_e s,
                                                input logic [WIDTH-1:0] p,
                                                input logic [WIDTH-1:0] l,
                                                input logic [WIDTH-1:0] d);
    case (s)
      SEL_PIN: return p;
      SEL_LAT: return l;
      SEL_DIR: return d;
      default: return '0;
    endcase
  endfunction

  assign pin_view = gate_pins(sync_v, ana_sel, pin_avail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= read_mux(sel, pin_view, lat_v, dir_v);
  end

  assign bus_rdata = rdata_q;

  // R6
  ana_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_PIN) |=> (bus_rdata & $past(ana_sel)) == '0);

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |=> bus_rdata == '0);

  // R7
  unavail_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_rdata & ~$past(pin_avail)) == '0);

  // R8
  ovr_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_a_en |-> pin_out[OVR_A_BIT] == ovr_a_val);

  // R8
  ovr_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_b_en |-> pin_out[OVR_B_BIT] == ovr_b_val);

  // R7
  oe_unavail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~pin_avail) == '0);
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, pin_out, pin_oe;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] ana_sel = 8'h00;
  logic [7:0] pin_avail = 8'hFF;
  logic       ovr_a_en = 1'b0, ovr_a_val = 1'b0, ovr_b_en = 1'b0, ovr_b_val = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_in(pin_in), .ana_sel(ana_sel), .pin_avail(pin_avail),
    .ovr_a_en(ovr_a_en), .ovr_a_val(ovr_a_val), .ovr_b_en(ovr_b_en),
    .ovr_b_val(ovr_b_val)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 oe", pin_oe, 8'h00);
    rd_reg(2'd2, d); check("R1 dir", d, 8'hFF);
    rd_reg(2'd1, d); check("R1 lat", d, 8'h00);
  endtask

  task automatic t_write_paths();
    logic [7:0] d;
    wr_reg(2'd1, 8'hA5); rd_reg(2'd1, d); check("R3 latch via offset 1", d, 8'hA5);
    wr_reg(2'd0, 8'h3C); rd_reg(2'd1, d); check("R3 latch via offset 0", d, 8'h3C);
    wr_reg(2'd2, 8'h0F); rd_reg(2'd2, d); check("R3 dir write", d, 8'h0F);
  endtask

  task automatic t_direction();
    wr_reg(2'd1, 8'h96);
    wr_reg(2'd2, 8'h0F);
    #1;
    check("R2 oe", pin_oe, 8'hF0);
    check("R2 out", pin_out, 8'h96);
  endtask

  task automatic t_latch_vs_pin();
    logic [7:0] d;
    wr_reg(2'd1, 8'h5A);
    settle_pins(8'hC3);
    rd_reg(2'd1, d); check("R4 latch not pins", d, 8'h5A);
    rd_reg(2'd0, d); check("R5 pin read", d, 8'hC3);
  endtask

  task automatic t_sync_latency();
    logic [7:0] d;
    @(negedge clk); bus_addr = 2'd0; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h81;
    @(negedge clk); d = bus_rdata; check("R5 old after 1 edge", d, 8'h00);
    @(negedge clk); d = bus_rdata; check("R5 old after 2 edges", d, 8'h00);
    @(negedge clk); d = bus_rdata; check("R5 new after 3 edges", d, 8'h81);
  endtask

  task automatic t_registered_read();
    logic [7:0] d;
    wr_reg(2'd1, 8'h11);
    wr_reg(2'd2, 8'hEE);
    rd_reg(2'd2, d); check("R10 dir", d, 8'hEE);
    @(negedge clk); bus_addr = 2'd1; #1;
    check("R10 before edge", bus_rdata, 8'hEE);
    @(negedge clk);
    check("R10 after edge", bus_rdata, 8'h11);
  endtask

  task automatic t_analog();
    logic [7:0] d;
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd2, 8'hFE);
    @(negedge clk); ana_sel = 8'h2F;
    settle_pins(8'hFF);
    rd_reg(2'd0, d); check("R6 pin read", d, 8'hD0);
    rd_reg(2'd1, d); check("R6 latch kept", d, 8'h01);
    rd_reg(2'd2, d); check("R6 dir kept", d, 8'hFE);
    check("R6 oe kept", pin_oe, 8'h01);
    @(negedge clk); ana_sel = 8'h00;
  endtask

  task automatic t_unavail();
    logic [7:0] d;
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd2, 8'h00);
    settle_pins(8'hFF);
    @(negedge clk); pin_avail = 8'hBF;
    rd_reg(2'd1, d); check("R7 latch masked", d, 8'hBF);
    rd_reg(2'd2, d); check("R7 dir masked", d, 8'h00);
    rd_reg(2'd0, d); check("R7 pin masked", d, 8'hBF);
    check("R7 oe", pin_oe, 8'hBF);
    wr_reg(2'd1, 8'h40); rd_reg(2'd1, d); check("R7 latch write ignored", d, 8'h00);
    wr_reg(2'd2, 8'hFF); rd_reg(2'd2, d); check("R7 dir write ignored", d, 8'hBF);
    @(negedge clk); pin_avail = 8'hFF;
    rd_reg(2'd2, d); check("R7 dir stays cleared", d, 8'hBF);
    rd_reg(2'd1, d); check("R7 latch stays cleared", d, 8'h00);
  endtask

  task automatic t_override();
    logic [7:0] d;
    wr_reg(2'd1, 8'h20);
    wr_reg(2'd2, 8'h00);
    @(negedge clk); ovr_a_en = 1'b1; ovr_a_val = 1'b1; ovr_b_en = 1'b0; #1;
    check("R8 a on", pin_out, 8'h30);
    @(negedge clk); ovr_b_en = 1'b1; ovr_b_val = 1'b0; #1;
    check("R8 b on", pin_out, 8'h10);
    check("R8 oe untouched", pin_oe, 8'hFF);
    rd_reg(2'd1, d); check("R8 latch untouched", d, 8'h20);
    @(negedge clk); ovr_a_en = 1'b0; ovr_b_en = 1'b0; #1;
    check("R8 off", pin_out, 8'h20);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr_reg(2'd1, 8'h77);
    wr_reg(2'd2, 8'h99);
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd3, d); check("R9 read zero", d, 8'h00);
    rd_reg(2'd1, d); check("R9 latch kept", d, 8'h77);
    rd_reg(2'd2, d); check("R9 dir kept", d, 8'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_paths();
    t_direction();
    t_latch_vs_pin();
    t_sync_latency();
    t_registered_read();
    t_analog();
    t_unavail();
    t_override();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule